// File: doc/BRIEF.md
# GPIO Interrupt Condition Controller

This block watches 32 general-purpose input pins and turns per-pin trigger conditions into sticky status bits and a single interrupt line. Each pin can fire on a low level, a high level, a rising edge, a falling edge, or on any change of its input. Software programs the conditions, a mask and an any-edge override through a small memory-mapped register port. It services interrupts by reading the status word and writing ones back to the bits it has handled.

Pin inputs must already be synchronous to `clk`. Edges are found by comparing each pin with its value sampled on the previous clock. A qualifying event sets the pin's status bit whether or not the pin is masked. The interrupt output is the registered OR of all status bits that are also enabled in the mask. The register port takes a write in the cycle that `wr_en` is high and returns read data on the cycle after `rd_en`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register (both condition words, mask, any-edge word, status) is 0, `irq` is 0 and `rd_data` is 0.
- R2: Registers sit at byte addresses 0x0C (condition word A), 0x10 (condition word B), 0x14 (mask), 0x18 (status) and 0x1C (any-edge). A write takes effect at the clock edge where `wr_en` is high. A read with `rd_en` high presents the register on `rd_data` after that clock edge, and `rd_data` holds until the next read.
- R3: Each pin has a 2-bit condition code: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. Pin p below 16 uses bits [2p+1:2p] of word A. Pin p of 16 or above uses bits [2(p-16)+1:2(p-16)] of word B.
- R4: Under a level code the status bit is set on every clock edge where the level is present. A clear write therefore only sticks once the level has gone away.
- R5: An edge code sets the status bit on the clock edge where the pin differs from its previous sampled value in the coded direction. A change in the other direction has no effect.
- R6: When a pin's bit in the any-edge word is 1, the pin sets status on both rising and falling changes, and its condition code is ignored.
- R7: Writing the status address clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R8: If a qualifying event and a clearing write hit the same status bit on the same clock edge, the bit stays set.
- R9: Status bits are set regardless of the mask. `irq` goes high one clock edge after some status bit and its mask bit are both 1, and falls one clock edge after no such pair remains.
- R10: A read of any other address returns 0. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Synchronised pin levels |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, registered |
| irq | output | 1 | Combined masked interrupt |

## Verification
A pin change driven between edges lands in status at the next rising edge. `irq` follows one edge after that, and a mask or clear write likewise moves `irq` one edge after the write edge. Read data appears after the single edge that samples `rd_en`. The bench drives every input on the falling edge and samples on the following falling edge. For `irq` it samples both the falling edge right after the causing edge and the one after it, so it confirms both the low-then-high shape and the one-cycle latency. Level conditions are checked by attempting a clear while the level holds and again after it is removed.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       pin_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CFGA = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_CFGB = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] A_ANY  = ADDR_W'(28);

  logic [31:0] cfg_a, cfg_b, mask_q, any_q, stat_q, pin_q, rd_q;
  logic        irq_q;
  logic [31:0] hit, clr, rd_mux;
  logic [63:0] codes;

  assign codes = {cfg_b, cfg_a};
  assign clr   = (wr_en && bus_addr == A_STAT) ? wr_data : 32'h0;

  for (genvar p = 0; p < 32; p++) begin : g_pin
    logic [1:0] code;
    logic       rise, fall;
    assign code = codes[2*p +: 2];
    assign rise = pin_in[p] & ~pin_q[p];
    assign fall = ~pin_in[p] & pin_q[p];
    assign hit[p] = any_q[p]     ? (rise | fall) :
                    (code == 2'd0) ? ~pin_in[p] :
                    (code == 2'd1) ?  pin_in[p] :
                    (code == 2'd2) ?  rise : fall;
  end

  always_comb begin
    case (bus_addr)
      A_CFGA:  rd_mux = cfg_a;
      A_CFGB:  rd_mux = cfg_b;
      A_MASK:  rd_mux = mask_q;
      A_STAT:  rd_mux = stat_q;
      A_ANY:   rd_mux = any_q;
      default: rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a  <= '0;
      cfg_b  <= '0;
      mask_q <= '0;
      any_q  <= '0;
      stat_q <= '0;
      pin_q  <= '0;
      rd_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pin_q  <= pin_in;
      stat_q <= (stat_q & ~clr) | hit;
      irq_q  <= |(stat_q & mask_q);
      if (rd_en) rd_q <= rd_mux;
      if (wr_en) begin
        if (bus_addr == A_CFGA) cfg_a  <= wr_data;
        if (bus_addr == A_CFGB) cfg_b  <= wr_data;
        if (bus_addr == A_MASK) mask_q <= wr_data;
        if (bus_addr == A_ANY)  any_q  <= wr_data;
      end
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       pin_in,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [31:0]       rd_data,
  input logic              irq,
  input logic [31:0]       cfg_a,
  input logic [31:0]       any_q,
  input logic [31:0]       mask_q,
  input logic [31:0]       stat_q
);
  logic stat_wr, mapped;
  assign stat_wr = wr_en && bus_addr == ADDR_W'(24);
  assign mapped  = bus_addr == ADDR_W'(12) || bus_addr == ADDR_W'(16) ||
                   bus_addr == ADDR_W'(20) || bus_addr == ADDR_W'(24) ||
                   bus_addr == ADDR_W'(28);

  assert_sticky_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat_q) & ~stat_q & ~($past(stat_wr) ? $past(wr_data) : 32'h0)) == 32'h0));

  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && !mapped) |-> rd_data == 32'h0);

  assert_mask_gates_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_q == 32'h0) |-> !irq);

  assert_any_edge_pin0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(any_q[0]) && $past(pin_in[0]) != $past(pin_in[0], 2)) |-> stat_q[0]);

  assert_high_level_pin0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_in[0] && cfg_a[1:0] == 2'd1 && !any_q[0]) |-> stat_q[0]);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
  .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
  .irq(irq), .cfg_a(cfg_a), .any_q(any_q), .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
  localparam logic [7:0] A_CFGA = 8'h0C, A_CFGB = 8'h10, A_MASK = 8'h14,
                         A_STAT = 8'h18, A_ANY  = 8'h1C;
  localparam logic [31:0] BASE = 32'hAAAA_AAAA;

  logic        clk = 0, rst_n = 0;
  logic [31:0] pin_in = 32'hFFFF_FFFF;
  logic [7:0]  bus_addr = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk); pin_in = v;
    @(negedge clk);
  endtask

  task automatic clear_all();
    logic [31:0] d;
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d);
    check("R7 clear all", d, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rd_data", rd_data, 0);
    check("R1 irq", {31'h0, irq}, 0);
    rd(A_STAT, d); check("R1 status", d, 0);
    rd(A_MASK, d); check("R1 mask", d, 0);
    rd(A_CFGB, d); check("R1 cfg B", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_CFGA, BASE); wr(A_CFGB, BASE);
    wr(A_MASK, 32'h1234_5678); wr(A_ANY, 32'h0000_00F0);
    rd(A_CFGA, d); check("R2 cfg A", d, BASE);
    rd(A_CFGB, d); check("R2 cfg B", d, BASE);
    rd(A_MASK, d); check("R2 mask", d, 32'h1234_5678);
    rd(A_ANY, d);  check("R2 any", d, 32'h0000_00F0);
    @(negedge clk); check("R2 rd_data holds", rd_data, 32'h0000_00F0);
    wr(A_ANY, 0); wr(A_MASK, 0);
    clear_all();
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(A_CFGB, (BASE & ~(32'h3 << 8)) | (32'h3 << 8));
    clear_all();
    pins(32'hFFFF_FFF7);
    rd(A_STAT, d); check("R5 pin3 falling ignored under rising code", d, 0);
    pins(32'hFFFF_FFFF);
    rd(A_STAT, d); check("R3 R5 pin3 rising", d, 32'h8);
    pins(32'hFFEF_FFFF);
    rd(A_STAT, d); check("R3 R5 pin20 falling", d, 32'h0010_0008);
    pins(32'hFFFF_FFFF);
    rd(A_STAT, d); check("R5 pin20 rising ignored", d, 32'h0010_0008);
    wr(A_CFGB, BASE);
    clear_all();
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(A_CFGA, (BASE & ~(32'h3 << 10)) | (32'h1 << 10));
    wr(A_STAT, 32'h20);
    rd(A_STAT, d); check("R4 high level resets after clear", d, 32'h20);
    pins(32'hFFFF_FFDF);
    wr(A_STAT, 32'h20);
    rd(A_STAT, d); check("R4 clear sticks after level gone", d, 0);
    pins(32'hFFFF_FFFF);
    wr(A_CFGA, BASE);
    clear_all();
    wr(A_CFGB, BASE & ~(32'h3 << 2));
    rd(A_STAT, d); check("R3 R4 pin17 low code while high", d, 0);
    pins(32'hFFFD_FFFF);
    wr(A_STAT, 32'h0002_0000);
    rd(A_STAT, d); check("R4 pin17 low level holds", d, 32'h0002_0000);
    pins(32'hFFFF_FFFF);
    wr(A_CFGB, BASE);
    clear_all();
  endtask

  task automatic t_anyedge();
    logic [31:0] d;
    wr(A_ANY, 32'h100);
    wr(A_CFGA, (BASE & ~(32'h3 << 16)) | (32'h1 << 16));
    clear_all();
    @(negedge clk);
    rd(A_STAT, d); check("R6 code ignored while any-edge set", d, 0);
    pins(32'hFFFF_FEFF);
    rd(A_STAT, d); check("R6 falling on pin8", d, 32'h100);
    wr(A_STAT, 32'h100);
    pins(32'hFFFF_FFFF);
    rd(A_STAT, d); check("R6 rising on pin8", d, 32'h100);
    wr(A_CFGA, BASE);
    wr(A_ANY, 0);
    clear_all();
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pins(32'hFFFF_FFFC);
    pins(32'hFFFF_FFFF);
    rd(A_STAT, d); check("R7 setup", d, 32'h3);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); check("R7 one bit cleared", d, 32'h2);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R7 zero write keeps", d, 32'h2);
    wr(A_STAT, 32'h2);
    rd(A_STAT, d); check("R7 last bit cleared", d, 0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pins(32'hFFFF_FFFB);
    @(negedge clk); pin_in = 32'hFFFF_FFFF;
    bus_addr = A_STAT; wr_data = 32'h4; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(A_STAT, d); check("R8 event beats clear", d, 32'h4);
    clear_all();
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pins(32'hFFFF_FFBF);
    pins(32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check("R9 unmasked stays low", {31'h0, irq}, 0);
    rd(A_STAT, d); check("R9 status set while masked", d, 32'h40);
    wr(A_MASK, 32'h40);
    check("R9 irq not yet at mask edge", {31'h0, irq}, 0);
    @(negedge clk); check("R9 irq one edge after mask", {31'h0, irq}, 1);
    wr(A_STAT, 32'h40);
    check("R9 irq still high at clear edge", {31'h0, irq}, 1);
    @(negedge clk); check("R9 irq falls after clear", {31'h0, irq}, 0);
    pins(32'hFFFF_FFBF);
    pins(32'hFFFF_FFFF);
    check("R9 irq low at event edge", {31'h0, irq}, 0);
    @(negedge clk); check("R9 irq one edge after event", {31'h0, irq}, 1);
    wr(A_MASK, 0);
    clear_all();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0D, 32'h5555_5555);
    rd(A_CFGA, d); check("R10 cfg A untouched", d, BASE);
    rd(A_MASK, d); check("R10 mask untouched", d, 0);
    rd(A_ANY, d);  check("R10 any untouched", d, 0);
    rd(8'h20, d);  check("R10 read 0x20", d, 0);
    rd(8'h04, d);  check("R10 read 0x04", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edges();
    t_level();
    t_anyedge();
    t_w1c();
    t_race();
    t_irq();
    t_unmapped();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule